// File: doc/BRIEF.md
# Linked-List DMA Transfer Sequencer

This block runs one DMA channel's transfer once the arbiter has granted it. A start pulse hands over the channel number, the source and destination addresses, a list pointer, a control word and the per-channel mask and option bits. The sequencer then copies one byte per beat through a memory port with separate read and write halves. Reads return data one cycle after they are issued, and every read is followed by its write in the next cycle. This gives a throughput of one beat per cycle.

Before the first beat the sequencer works out an effective transfer. Addresses on the internal-memory side are forced to half-word alignment and the size is rounded up to an even count. The burst length comes from a three-bit code, and the size is raised to at least one burst. In multi-block mode the sequencer reads a four-word descriptor from memory and keeps following the chain until it reads a zero next pointer. In auto-init mode it restarts the same block every time it completes. In single-block mode it stops, pulses a request to clear the channel's enable bit and returns to idle. Half-done and block-done events set sticky cause bits and request bits for each channel, and they pulse one interrupt line that all channels share.

Top module: `ll_dma_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `irq`, `mem_rd`, `mem_wr` and `en_clr` are 0, and `irq_req`, `cause_half` and `cause_blk` are all zero.
- R2: Each beat reads one byte at the current source address (`mem_word`=0), and that byte is written to the current destination in the following cycle. An address steps up by one after each beat unless its fixed bit is set. A beat can be issued every cycle.
- R3: The control word holds mode in [1:0], direction in [4:2], burst code in [7:5] and size in [8+SZW-1:8]. Directions 0, 1 and 2 clear the source LSB. Directions 0, 3 and 4 clear the destination LSB. For each of directions 0 to 4 the size is rounded up to even. Directions 5 to 7 leave the addresses and the size unchanged.
- R4: The burst length is set by the burst code:
  - Code 0 gives 2 beats if either effective address lies in [SRAM_LO, SRAM_HI) and the channel is outside [UART_LO, UART_HI]. Otherwise code 0 gives 1 beat.
  - Codes 1 to 6 give 2^(code+1) beats.
  - Code 7 gives 1024 beats.
  - `burst_end` pulses with the last write of each burst and with the last write of the block.
- R5: When the burst length exceeds the effective size, the block moves one full burst.
- R6: With source-fixed set, every read uses the same address and `per_rd_stb` pulses with each read. With destination-fixed set, every write uses the same address and `per_wr_stb` pulses with each write.
- R7: With the half mask clear, a half-done event occurs on the write whose running count equals total/2+1.
- R8: A descriptor is four words at pointer+0, +4, +8 and +12, read in the order control, next pointer, source, destination. It is fetched at the start only in modes 2 and 3, and only if the start pointer is nonzero. Modes 0 (single) and 1 (auto-init) never read one.
- R9: At the end of a block whose fetched next pointer is nonzero, block-done occurs if its mask is clear, whatever the all/half select bit holds. The next descriptor is then fetched and run.
- R10: At the end of the last block in modes 0, 2 and 3, `en_clr` pulses for one cycle and `busy` falls in the same cycle. Block-done occurs there only if its mask is clear and the all/half select bit is 0.
- R11: In mode 1 the block restarts from the same source, destination and size after each completion, without pulsing `en_clr`.
- R12: Every event pulses `irq` for one cycle after the write that caused it, at most once per write. The event also sets the channel's bit in `irq_req` and its half or block cause bit. `irq_ack` clears those bits, and a new event wins over an ack in the same cycle.
- R13: When `ch_en` is low during a transfer, no further reads are issued. The write of a beat already read still completes, and the block then returns to idle with no event and no `en_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin service of the granted channel (taken while idle) |
| start_ch | input | CHW | Granted channel number |
| start_src | input | AW | Programmed source address |
| start_dst | input | AW | Programmed destination address |
| start_llp | input | AW | Programmed descriptor pointer |
| start_ctl | input | 8+SZW | Programmed control word |
| start_mask_half | input | 1 | 1 masks the half-done event |
| start_mask_blk | input | 1 | 1 masks the block-done event |
| start_all_half | input | 1 | 1 suppresses block-done on the final block |
| start_src_fixed | input | 1 | Source address does not step |
| start_dst_fixed | input | 1 | Destination address does not step |
| ch_en | input | 1 | Enable of the served channel |
| busy | output | 1 | A transfer is in progress |
| mem_rd | output | 1 | Memory read request |
| mem_word | output | 1 | Read is a descriptor word (else a byte) |
| mem_raddr | output | AW | Read address |
| mem_rdata | input | AW | Read data, valid one cycle after `mem_rd` |
| mem_wr | output | 1 | Memory byte write |
| mem_waddr | output | AW | Write address |
| mem_wdata | output | 8 | Write byte |
| per_rd_stb | output | 1 | Peripheral read trigger for a fixed source |
| per_wr_stb | output | 1 | Peripheral write trigger for a fixed destination |
| burst_end | output | 1 | Last write of a burst |
| irq | output | 1 | Shared interrupt pulse |
| irq_req | output | NCH | Per-channel pending interrupt bits |
| cause_half | output | NCH | Per-channel half-done cause bits |
| cause_blk | output | NCH | Per-channel block-done cause bits |
| irq_ack | input | NCH | Clears the matching request and cause bits |
| en_clr | output | 1 | Pulse requesting that the served channel's enable be cleared |

## Verification
The bench targets these corner cases:
- **Odd addresses and odd sizes in internal memory.** A design that skips the alignment would copy a byte too few, or write to the wrong half-word.
- **Burst sizing.** Tiny sizes must be raised to the burst length, code 7 must give 1024 beats, and the UART channel exception must apply. A wrong decode shows up as the wrong write count or `burst_end` count.
- **Half-done position.** A one-beat block puts half-done and block-done on the same write, and a six-byte block puts half-done on write four. An off-by-one lands on another write or merges the two pulses.
- **Chain versus final block.** The chain test checks the descriptor word order and that the all/half select bit suppresses only the final block-done.
- **Auto-init and dropped enable.** These must stop without `en_clr` or spurious events. A design that ignores the enable would keep writing past the stop.

// File: rtl/ll_dma_seq.sv
module ll_dma_seq #(
  parameter int AW = 32,
  parameter int SZW = 12,
  parameter int NCH = 8,
  parameter int UART_LO = 4,
  parameter int UART_HI = 6,
  parameter logic [AW-1:0] SRAM_LO = 'h0001_0000,
  parameter logic [AW-1:0] SRAM_HI = 'h0002_0000,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW = 8 + SZW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic [AW-1:0]  start_src,
  input  logic [AW-1:0]  start_dst,
  input  logic [AW-1:0]  start_llp,
  input  logic [CW-1:0]  start_ctl,
  input  logic           start_mask_half,
  input  logic           start_mask_blk,
  input  logic           start_all_half,
  input  logic           start_src_fixed,
  input  logic           start_dst_fixed,
  input  logic           ch_en,
  output logic           busy,
  output logic           mem_rd,
  output logic           mem_word,
  output logic [AW-1:0]  mem_raddr,
  input  logic [AW-1:0]  mem_rdata,
  output logic           mem_wr,
  output logic [AW-1:0]  mem_waddr,
  output logic [7:0]     mem_wdata,
  output logic           per_rd_stb,
  output logic           per_wr_stb,
  output logic           burst_end,
  output logic           irq,
  output logic [NCH-1:0] irq_req,
  output logic [NCH-1:0] cause_half,
  output logic [NCH-1:0] cause_blk,
  input  logic [NCH-1:0] irq_ack,
  output logic           en_clr
);
  localparam int TW = SZW + 1;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_INIT, S_XFER} st_t;
  st_t st;

  logic [CHW-1:0] ch_r;
  logic [AW-1:0]  src_r, dst_r, llp_r, desc_base, cur_src, cur_dst;
  logic [CW-1:0]  ctl_r;
  logic [2:0]     fcnt;
  logic [1:0]     fidx;
  logic           fpend, chain, wr_pend;
  logic           m_half, m_blk, all_half, fix_s, fix_d;
  logic [TW-1:0]  total, blen, iss, wcnt;

  wire [1:0]     c_mode = ctl_r[1:0];
  wire [2:0]     c_dir  = ctl_r[4:2];
  wire [2:0]     c_bc   = ctl_r[7:5];
  wire [SZW-1:0] c_size = ctl_r[CW-1:8];

  wire m_src = (c_dir == 3'd0) || (c_dir == 3'd1) || (c_dir == 3'd2);
  wire m_dst = (c_dir == 3'd0) || (c_dir == 3'd3) || (c_dir == 3'd4);
  wire [AW-1:0] e_src = m_src ? {src_r[AW-1:1], 1'b0} : src_r;
  wire [AW-1:0] e_dst = m_dst ? {dst_r[AW-1:1], 1'b0} : dst_r;
  wire [TW-1:0] size_raw = TW'(c_size);
  wire [TW-1:0] size_e = (m_src || m_dst) ? ((size_raw + TW'(1)) & ~TW'(1)) : size_raw;

  wire in_sram = (e_src >= SRAM_LO && e_src < SRAM_HI) || (e_dst >= SRAM_LO && e_dst < SRAM_HI);
  wire is_uart = (int'(ch_r) >= UART_LO) && (int'(ch_r) <= UART_HI);

  logic [TW-1:0] burst_e;
  always_comb begin
    case (c_bc)
      3'd0:    burst_e = (in_sram && !is_uart) ? TW'(2) : TW'(1);
      3'd7:    burst_e = TW'(1024);
      default: burst_e = TW'(1) << (c_bc + 3'd1);
    endcase
  end
  wire [TW-1:0] total_e = (burst_e > size_e) ? burst_e : size_e;

  wire [TW-1:0] wnext = wcnt + TW'(1);
  wire rd_go   = (st == S_XFER) && ch_en && (iss < total);
  wire f_issue = (st == S_FETCH) && (fcnt < 3'd4);
  wire last_wr = wr_pend && (wnext == total);
  wire half_ev = wr_pend && !m_half && (wnext == (total >> 1) + TW'(1));
  wire blk_ev  = last_wr && !m_blk && (chain || !all_half);
  wire [NCH-1:0] sel = NCH'(1) << ch_r;

  assign busy       = (st != S_IDLE);
  assign mem_rd     = rd_go || f_issue;
  assign mem_word   = (st == S_FETCH);
  assign mem_raddr  = (st == S_FETCH) ? desc_base + AW'({fcnt[1:0], 2'b00}) : cur_src;
  assign mem_wr     = wr_pend;
  assign mem_waddr  = cur_dst;
  assign mem_wdata  = mem_rdata[7:0];
  assign per_rd_stb = rd_go && fix_s;
  assign per_wr_stb = wr_pend && fix_d;
  assign burst_end  = wr_pend && (((wnext & (blen - TW'(1))) == '0) || last_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ch_r <= '0; src_r <= '0; dst_r <= '0; llp_r <= '0; ctl_r <= '0;
      desc_base <= '0; cur_src <= '0; cur_dst <= '0; fcnt <= '0; fidx <= '0;
      fpend <= 1'b0; chain <= 1'b0; wr_pend <= 1'b0;
      m_half <= 1'b1; m_blk <= 1'b1; all_half <= 1'b0; fix_s <= 1'b0; fix_d <= 1'b0;
      total <= '0; blen <= TW'(1); iss <= '0; wcnt <= '0;
      irq <= 1'b0; irq_req <= '0; cause_half <= '0; cause_blk <= '0; en_clr <= 1'b0;
    end else begin
      en_clr <= 1'b0;
      irq <= half_ev || blk_ev;
      cause_half <= (cause_half & ~irq_ack) | ({NCH{half_ev}} & sel);
      cause_blk  <= (cause_blk & ~irq_ack) | ({NCH{blk_ev}} & sel);
      irq_req    <= (irq_req & ~irq_ack) | ({NCH{half_ev || blk_ev}} & sel);
      fpend <= f_issue;
      fidx  <= fcnt[1:0];
      case (st)
        S_IDLE: if (start) begin
          ch_r <= start_ch; src_r <= start_src; dst_r <= start_dst;
          llp_r <= start_llp; ctl_r <= start_ctl;
          m_half <= start_mask_half; m_blk <= start_mask_blk; all_half <= start_all_half;
          fix_s <= start_src_fixed; fix_d <= start_dst_fixed;
          chain <= 1'b0;
          if (start_ctl[1] && start_llp != '0) begin
            st <= S_FETCH; desc_base <= start_llp; fcnt <= '0;
          end else st <= S_INIT;
        end
        S_FETCH: begin
          if (f_issue) fcnt <= fcnt + 3'd1;
          if (fpend) begin
            case (fidx)
              2'd0: ctl_r <= mem_rdata[CW-1:0];
              2'd1: llp_r <= mem_rdata;
              2'd2: src_r <= mem_rdata;
              default: begin
                dst_r <= mem_rdata;
                chain <= (llp_r != '0);
                st <= S_INIT;
              end
            endcase
          end
        end
        S_INIT: begin
          cur_src <= e_src; cur_dst <= e_dst; total <= total_e; blen <= burst_e;
          iss <= '0; wcnt <= '0; wr_pend <= 1'b0; st <= S_XFER;
        end
        default: begin
          wr_pend <= rd_go;
          if (rd_go) begin
            iss <= iss + TW'(1);
            if (!fix_s) cur_src <= cur_src + AW'(1);
          end
          if (wr_pend) begin
            wcnt <= wnext;
            if (!fix_d) cur_dst <= cur_dst + AW'(1);
          end
          if (last_wr) begin
            if (chain) begin
              st <= S_FETCH; desc_base <= llp_r; fcnt <= '0;
            end else if (c_mode == 2'd1) st <= S_INIT;
            else begin
              st <= S_IDLE; en_clr <= 1'b1;
            end
          end else if (!ch_en && !wr_pend) st <= S_IDLE;
        end
      endcase
    end
  end

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd && !mem_word)); // R2
  AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_XFER) |-> (wcnt <= total)); // R5
  AST_PER_RD_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    per_rd_stb |-> (mem_rd && !mem_word)); // R6
  AST_NO_WR_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_word |-> !mem_wr); // R8
  AST_ENCLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr |-> !busy); // R10
  AST_IRQ_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_req != '0)); // R12
endmodule

// File: tb/sim_ll_dma_seq.sv
`timescale 1ns/1ps
module sim_ll_dma_seq;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic start = 0, ch_en = 1;
  logic [2:0] start_ch = 0;
  logic [31:0] start_src = 0, start_dst = 0, start_llp = 0;
  logic [19:0] start_ctl = 0;
  logic s_mh = 1, s_mb = 1, s_ah = 0, s_fs = 0, s_fd = 0;
  logic busy, mem_rd, mem_word, mem_wr, per_rd_stb, per_wr_stb, burst_end, irq, en_clr;
  logic [31:0] mem_raddr, mem_waddr, mem_rdata;
  logic [7:0] mem_wdata;
  logic [7:0] irq_req, cause_half, cause_blk, irq_ack = 0;

  ll_dma_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .start_ch(start_ch),
    .start_src(start_src), .start_dst(start_dst), .start_llp(start_llp), .start_ctl(start_ctl),
    .start_mask_half(s_mh), .start_mask_blk(s_mb), .start_all_half(s_ah),
    .start_src_fixed(s_fs), .start_dst_fixed(s_fd), .ch_en(ch_en), .busy(busy),
    .mem_rd(mem_rd), .mem_word(mem_word), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .per_rd_stb(per_rd_stb), .per_wr_stb(per_wr_stb), .burst_end(burst_end), .irq(irq),
    .irq_req(irq_req), .cause_half(cause_half), .cause_blk(cause_blk), .irq_ack(irq_ack),
    .en_clr(en_clr));

  logic [7:0] mem [0:4095];
  function automatic int ix(input logic [31:0] a);
    return int'({a[16], a[10:0]});
  endfunction
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_word ?
      {mem[ix(mem_raddr+3)], mem[ix(mem_raddr+2)], mem[ix(mem_raddr+1)], mem[ix(mem_raddr)]} :
      {24'h0, mem[ix(mem_raddr)]};
    if (mem_wr) mem[ix(mem_waddr)] <= mem_wdata;
  end

  int nwr, nwrd, nbe, nprd, npwr, nirq, nenc;
  int irq_at [0:7];
  always @(negedge clk) begin
    if (irq) begin if (nirq < 8) irq_at[nirq] = nwr; nirq++; end
    if (mem_wr) nwr++;
    if (mem_rd && mem_word) nwrd++;
    if (burst_end) nbe++;
    if (per_rd_stb) nprd++;
    if (per_wr_stb) npwr++;
    if (en_clr) nenc++;
  end

  int nt = 0, nf = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nt++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mkc(input int mode, dir, bc, size);
    return 20'(size << 8 | bc << 5 | dir << 2 | mode);
  endfunction
  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[ix(a + k)] = v[8*k +: 8];
  endtask

  task automatic clr_cnt;
    nwr = 0; nwrd = 0; nbe = 0; nprd = 0; npwr = 0; nirq = 0; nenc = 0;
  endtask

  task automatic launch(input int ch, input logic [31:0] s, d, l, input logic [19:0] c);
    @(negedge clk); #1;
    clr_cnt();
    start_ch = 3'(ch); start_src = s; start_dst = d; start_llp = l; start_ctl = c;
    start = 1;
    @(negedge clk); #1;
    start = 0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 3000) begin @(negedge clk); #1; t++; end
    chk({tag, " timeout"}, 32'(t < 3000), 1);
    @(negedge clk); @(negedge clk); #1;
  endtask

  task automatic t_single;
    for (int k = 0; k < 8; k++) mem[ix(32'h400 + k)] = 8'hEE;
    s_mh = 1; s_mb = 0; s_ah = 0; s_fs = 0; s_fd = 0;
    launch(0, 32'h0, 32'h400, 32'h10700, mkc(0, 5, 0, 5));
    wait_idle("R2");
    chk("R2 writes", nwr, 5);
    for (int k = 0; k < 5; k++) chk("R2 data", mem[ix(32'h400 + k)], mem[ix(k)]);
    chk("R2 no overrun", mem[ix(32'h405)], 8'hEE);
    chk("R4 burst1 ends", nbe, 5);
    chk("R8 no fetch in single", nwrd, 0);
    chk("R10 en_clr", nenc, 1);
    chk("R10 irq count", nirq, 1);
    chk("R12 cause_blk", cause_blk[0], 1);
    chk("R12 irq_req", irq_req[0], 1);
    chk("R7 half masked", cause_half[0], 0);
  endtask

  task automatic t_ack;
    @(negedge clk); #1; irq_ack = 8'h01;
    @(negedge clk); #1; irq_ack = 8'h00;
    chk("R12 ack cause", cause_blk[0], 0);
    chk("R12 ack req", irq_req[0], 0);
  endtask

  task automatic t_align;
    for (int k = 0; k < 8; k++) mem[ix(32'h10100 + k)] = 8'hEE;
    s_mh = 0; s_mb = 0; s_ah = 0;
    launch(3, 32'h10001, 32'h10101, 0, mkc(0, 0, 0, 5));
    wait_idle("R3");
    chk("R3 rounded writes", nwr, 6);
    for (int k = 0; k < 6; k++) chk("R3 aligned data", mem[ix(32'h10100 + k)], mem[ix(32'h10000 + k)]);
    chk("R3 beyond", mem[ix(32'h10106)], 8'hEE);
    chk("R4 sram burst2 ends", nbe, 3);
    chk("R7 irq count", nirq, 2);
    chk("R7 half position", irq_at[0], 4);
    chk("R7 half cause", cause_half[3], 1);
    s_mh = 1;
  endtask

  task automatic t_raise;
    s_mb = 1;
    launch(0, 32'h100, 32'h500, 0, mkc(0, 5, 2, 3));
    wait_idle("R5");
    chk("R5 raised to burst", nwr, 8);
    chk("R4 code2 one burst", nbe, 1);
    chk("R5 last byte", mem[ix(32'h507)], mem[ix(32'h107)]);
    chk("R10 masked blk no irq", nirq, 0);
    launch(0, 32'h0, 32'h400, 0, mkc(0, 5, 7, 10));
    wait_idle("R4");
    chk("R4 code7 1024 beats", nwr, 1024);
    chk("R4 code7 one burst", nbe, 1);
    chk("R4 far byte", mem[ix(32'h7FF)], mem[ix(32'h3FF)]);
  endtask

  task automatic t_uart;
    launch(1, 32'h10200, 32'h600, 0, mkc(0, 5, 0, 1));
    wait_idle("R4");
    chk("R4 sram non-uart burst2", nwr, 2);
    launch(5, 32'h10200, 32'h600, 0, mkc(0, 5, 0, 1));
    wait_idle("R4");
    chk("R4 uart burst1", nwr, 1);
  endtask

  task automatic t_fixed;
    for (int k = 0; k < 4; k++) begin mem[ix(32'h500 + k)] = 8'hEE; mem[ix(32'h520 + k)] = 8'hEE; end
    s_fs = 1; s_fd = 0;
    launch(0, 32'h10, 32'h500, 0, mkc(0, 5, 0, 4));
    wait_idle("R6");
    for (int k = 0; k < 4; k++) chk("R6 src fixed data", mem[ix(32'h500 + k)], mem[ix(32'h10)]);
    chk("R6 rd strobes", nprd, 4);
    chk("R6 no wr strobes", npwr, 0);
    s_fs = 0; s_fd = 1;
    launch(0, 32'h20, 32'h520, 0, mkc(0, 5, 0, 4));
    wait_idle("R6");
    chk("R6 dst fixed last", mem[ix(32'h520)], mem[ix(32'h23)]);
    chk("R6 dst untouched", mem[ix(32'h521)], 8'hEE);
    chk("R6 wr strobes", npwr, 4);
    s_fd = 0;
  endtask

  task automatic t_chain(input logic ah, input int exp_irq);
    put32(32'h10700, 32'(mkc(2, 5, 0, 3))); put32(32'h10704, 32'h10720);
    put32(32'h10708, 32'h40);               put32(32'h1070C, 32'h540);
    put32(32'h10720, 32'(mkc(2, 5, 0, 2))); put32(32'h10724, 32'h0);
    put32(32'h10728, 32'h50);               put32(32'h1072C, 32'h550);
    for (int k = 0; k < 4; k++) begin
      mem[ix(32'h540 + k)] = 8'hEE; mem[ix(32'h550 + k)] = 8'hEE; mem[ix(32'h560 + k)] = 8'hEE;
    end
    s_mb = 0; s_ah = ah;
    launch(6, 32'h60, 32'h560, 32'h10700, mkc(2, 5, 0, 7));
    wait_idle("R8");
    chk("R8 word reads", nwrd, 8);
    chk("R9 total writes", nwr, 5);
    for (int k = 0; k < 3; k++) chk("R8 block1 data", mem[ix(32'h540 + k)], mem[ix(32'h40 + k)]);
    for (int k = 0; k < 2; k++) chk("R9 block2 data", mem[ix(32'h550 + k)], mem[ix(32'h50 + k)]);
    chk("R8 block1 size", mem[ix(32'h543)], 8'hEE);
    chk("R8 start regs unused", mem[ix(32'h560)], 8'hEE);
    chk(ah ? "R9 chain irq only" : "R10 chain plus final irq", nirq, exp_irq);
    chk("R9 chain irq after block1", irq_at[0], 3);
    chk("R10 chain en_clr", nenc, 1);
    s_ah = 0;
  endtask

  task automatic t_auto;
    int t = 0;
    s_mb = 0; s_ah = 0;
    launch(7, 32'h80, 32'h580, 0, mkc(1, 5, 0, 3));
    while (nwr < 7 && t < 200) begin @(negedge clk); #1; t++; end
    ch_en = 0;
    wait_idle("R13");
    ch_en = 1;
    chk("R11 restarted", 32'(nwr >= 7 && nwr <= 8), 1);
    chk("R11 irq per block", nirq, 2);
    chk("R11 no en_clr", nenc, 0);
    chk("R11 data", mem[ix(32'h582)], mem[ix(32'h82)]);
  endtask

  task automatic t_abort;
    int t = 0;
    s_mb = 0;
    launch(0, 32'h90, 32'h590, 0, mkc(0, 5, 0, 20));
    while (nwr < 5 && t < 200) begin @(negedge clk); #1; t++; end
    ch_en = 0;
    wait_idle("R13");
    ch_en = 1;
    chk("R13 stopped", 32'(nwr >= 5 && nwr <= 6), 1);
    chk("R13 no irq", nirq, 0);
    chk("R13 no en_clr", nenc, 0);
    chk("R13 idle", busy, 0);
  endtask

  task automatic t_one;
    s_mh = 0; s_mb = 0;
    launch(2, 32'hA0, 32'h5A0, 0, mkc(0, 5, 0, 1));
    wait_idle("R7");
    chk("R7 single pulse", nirq, 1);
    chk("R7 half cause", cause_half[2], 1);
    chk("R12 blk cause", cause_blk[2], 1);
    s_mh = 1;
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = 8'(k * 7 + 3);
    clr_cnt();
    repeat (4) @(negedge clk);
    rst_n = 1; #1;
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem", {mem_rd, mem_wr, en_clr}, 0);
    chk("R1 bits", {irq_req, cause_half, cause_blk}, 0);
    t_single(); t_ack(); t_align(); t_raise(); t_uart(); t_fixed();
    t_chain(1, 1); t_chain(0, 2); t_auto(); t_abort(); t_one();
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    #(5 * 150000);
    nt++; nf++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule